// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block is the part of a bus master that answers a maskable interrupt. When the interrupt request line is high and interrupts are enabled, it runs two interrupt-acknowledge bus cycles, one after the other. Address bit 2 is the only thing that tells the two cycles apart. Each cycle stays open until the slave signals ready. The 8-bit interrupt vector is taken from the low data byte when the second cycle ends. A one-clock valid pulse then announces the vector.

Every acknowledge cycle starts with a one-clock address strobe, followed by a wait phase that lasts until ready is seen. After each cycle the bus is held idle for a fixed number of clocks, and no strobe may be issued during that gap. While an acknowledge cycle is open, the bus-definition status carries the acknowledge code. At all other times it carries the idle code.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts, with the address strobe high on the clock after the request is seen, only when `irq` and `int_en` are both high while the block is idle. Otherwise no strobe is issued.
- R2: Each accepted interrupt produces exactly two acknowledge cycles, meaning exactly two strobe pulses, before the vector is announced.
- R3: Once its strobe clock is over, an acknowledge cycle stays in its wait phase (status acknowledge, strobe low) for as long as `rdy` is sampled low. It ends on the first clock edge in the wait phase where `rdy` is high. `rdy` is not looked at during the strobe clock.
- R4: During the first cycle, `addr_word` (the byte address shifted right by 2) equals 1, which is byte address 4.
- R5: During the second cycle, `addr_word` equals 0.
- R6: While a cycle is open, `be_n` is 4'b1110 (only byte lane 0 active). At all other times it is 4'b1111. `addr_word` is 0 when no cycle is open.
- R7: `vector` takes `data_in` on the edge that completes the second cycle. It keeps that value until the next completion, whatever the bus carries in the meantime.
- R8: After each acknowledge cycle, exactly IDLE_CLKS (default 2) idle clocks follow, with status idle and strobe low, before the next strobe.
- R9: `bus_stat` is 2'b01 (acknowledge) during both cycles and 2'b00 (idle) at all other times.
- R10: `vec_vld` is high for exactly one clock, the first clock after the vector is latched. A request is not acted on until that pulse has been issued.
- R11: A synchronous active-high `rst` returns the block to idle. Strobe and `vec_vld` go low, status becomes idle and any cycle in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Level-sensitive interrupt request |
| int_en | input | 1 | Interrupt enable flag |
| rdy | input | 1 | Cycle-complete handshake from the slave |
| data_in | input | 8 | Low byte of the data bus |
| addr_word | output | 30 | Word address (byte address bits 31..2) |
| be_n | output | 4 | Byte enables, active low |
| bus_stat | output | 2 | Bus-definition status: 00 idle, 01 acknowledge |
| strobe | output | 1 | Address strobe, high for the first clock of each cycle |
| vector | output | 8 | Latched interrupt vector |
| vec_vld | output | 1 | One-clock pulse, vector is new |

## Verification
The assertions assume that `rdy` matters only in the wait phase and that `data_in` is valid on the edge where `rdy` completes the second cycle. They assume nothing about the bus in other clocks. The stimulus raises `rdy` for a single clock only once a cycle is past its strobe clock, and presents the vector byte only on that completing edge. In the other clocks it drives unrelated byte values on the data bus, so that any early or late capture shows up. The request and enable inputs change only away from the clock edge. Some tests hold the request high across the end of a sequence so that back-to-back sequences occur.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 8,
  parameter int IDLE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              int_en,
  input  logic              rdy,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-3:0] addr_word,
  output logic [3:0]        be_n,
  output logic [1:0]        bus_stat,
  output logic              strobe,
  output logic [DATA_W-1:0] vector,
  output logic              vec_vld
);

  localparam int WA_W  = ADDR_W - 2;
  localparam int GAP_W = $clog2(IDLE_CLKS + 1);
  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_ACK  = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_ADR1, S_WT1, S_GAP1, S_ADR2, S_WT2, S_GAP2
  } state_t;

  state_t           st;
  logic [GAP_W-1:0] gap;

  wire gap_done = (gap == GAP_W'(IDLE_CLKS - 1));
  wire in_cyc   = (st == S_ADR1) || (st == S_WT1) || (st == S_ADR2) || (st == S_WT2);
  wire first    = (st == S_ADR1) || (st == S_WT1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      gap     <= '0;
      vector  <= '0;
      vec_vld <= 1'b0;
    end else begin
      vec_vld <= 1'b0;
      case (st)
        S_IDLE: if (irq && int_en) st <= S_ADR1;
        S_ADR1: st <= S_WT1;
        S_WT1:  if (rdy) begin st <= S_GAP1; gap <= '0; end
        S_GAP1: begin
          gap <= gap + 1'b1;
          if (gap_done) st <= S_ADR2;
        end
        S_ADR2: st <= S_WT2;
        S_WT2:  if (rdy) begin
          st      <= S_GAP2;
          gap     <= '0;
          vector  <= data_in;
          vec_vld <= 1'b1;
        end
        S_GAP2: begin
          gap <= gap + 1'b1;
          if (gap_done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign strobe    = (st == S_ADR1) || (st == S_ADR2);
  assign bus_stat  = in_cyc ? ST_ACK : ST_IDLE;
  assign be_n      = in_cyc ? 4'b1110 : 4'b1111;
  assign addr_word = (in_cyc && first) ? WA_W'(1) : '0;

  // ---------------- assertion support ----------------
  logic [1:0]  n_strb;
  logic [31:0] idle_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_strb   <= '0;
      idle_run <= 32'(IDLE_CLKS);
    end else begin
      if (st == S_IDLE)   n_strb <= '0;
      else if (strobe)    n_strb <= n_strb + 1'b1;
      if (bus_stat == ST_ACK)              idle_run <= '0;
      else if (idle_run < 32'(IDLE_CLKS))  idle_run <= idle_run + 1;
    end
  end

  a_r1_start_gated: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !(irq && int_en)) |=> !strobe);
  a_r2_two_cycles: assert property (@(posedge clk) disable iff (rst)
    vec_vld |-> (n_strb == 2'd2));
  a_r3_hold_open: assert property (@(posedge clk) disable iff (rst)
    (bus_stat == ST_ACK && !strobe && !rdy) |=> (bus_stat == ST_ACK && !strobe));
  a_r4_addr_first: assert property (@(posedge clk) disable iff (rst)
    (strobe && n_strb == 2'd0) |-> (addr_word == WA_W'(1)));
  a_r5_addr_second: assert property (@(posedge clk) disable iff (rst)
    (strobe && n_strb == 2'd1) |-> (addr_word == '0));
  a_r6_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_stat == ST_ACK) ? (be_n == 4'b1110) : (be_n == 4'b1111 && addr_word == '0));
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_vld) |-> (vector == $past(data_in)));
  a_r8_idle_gap: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (idle_run >= 32'(IDLE_CLKS)));
  a_r9_status: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (bus_stat == ST_ACK));
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    vec_vld |=> !vec_vld);

endmodule

// File: tb/test_intack_seq.sv
module test_intack_seq;
  logic clk = 1'b0;
  logic rst, irq, int_en, rdy;
  logic [7:0]  data_in;
  logic [29:0] addr_word;
  logic [3:0]  be_n;
  logic [1:0]  bus_stat;
  logic strobe, vec_vld;
  logic [7:0] vector;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  intack_seq i_intack_seq (
    .clk(clk), .rst(rst), .irq(irq), .int_en(int_en), .rdy(rdy),
    .data_in(data_in), .addr_word(addr_word), .be_n(be_n),
    .bus_stat(bus_stat), .strobe(strobe), .vector(vector), .vec_vld(vec_vld)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {strobe, bus_stat, be_n, addr_word}, {1'b0, 2'b00, 4'b1111, 30'd0});
  endtask

  task automatic chk_open(input string req, input logic stb, input logic [29:0] wa);
    chk(req, {strobe, bus_stat, be_n, addr_word}, {stb, 2'b01, 4'b1110, wa});
  endtask

  // call at a negedge with the block idle
  task automatic run_seq(input int w1, input int w2, input logic [7:0] v, input logic keep);
    irq = 1'b1; int_en = 1'b1; rdy = 1'b0; data_in = ~v;
    @(negedge clk); chk_open("R1/R4 strobe cycle1", 1'b1, 30'd1);
    if (!keep) irq = 1'b0;
    @(negedge clk); chk_open("R3/R4 wait cycle1", 1'b0, 30'd1);
    for (int i = 0; i < w1; i++) begin
      @(negedge clk); chk_open("R3 held cycle1", 1'b0, 30'd1);
    end
    rdy = 1'b1;
    @(negedge clk); rdy = 1'b0; chk_idle("R8/R9 gap1 clk1");
    @(negedge clk); chk_idle("R8 gap1 clk2");
    @(negedge clk); chk_open("R2/R5 strobe cycle2", 1'b1, 30'd0);
    @(negedge clk); chk_open("R3/R5 wait cycle2", 1'b0, 30'd0);
    for (int i = 0; i < w2; i++) begin
      data_in = 8'h5A ^ 8'(i);
      @(negedge clk); chk_open("R3 held cycle2", 1'b0, 30'd0);
    end
    rdy = 1'b1; data_in = v;
    @(negedge clk); rdy = 1'b0; data_in = ~v;
    chk("R7 vector", vector, v);
    chk("R10 pulse high", vec_vld, 1'b1);
    chk_idle("R8 gap2 clk1");
    @(negedge clk);
    chk("R10 pulse one clock", vec_vld, 1'b0);
    chk("R7 vector held", vector, v);
    chk_idle("R8 gap2 clk2");
    @(negedge clk); chk_idle("R2 no third cycle");
  endtask

  task automatic t_reset();
    rst = 1'b1; irq = 1'b0; int_en = 1'b0; rdy = 1'b0; data_in = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_idle("R11 reset outputs");
    chk("R11 reset vec_vld", vec_vld, 1'b0);
  endtask

  task automatic t_ignored();
    irq = 1'b1; int_en = 1'b0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); chk_idle("R1 masked request"); end
    irq = 1'b0; int_en = 1'b1;
    for (int i = 0; i < 5; i++) begin @(negedge clk); chk_idle("R1 no request"); end
    int_en = 1'b0;
  endtask

  task automatic t_back_to_back();
    run_seq(0, 0, 8'h11, 1'b1);
    @(negedge clk); chk_open("R10 restart after pulse", 1'b1, 30'd1);
    irq = 1'b0;
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    @(negedge clk); rdy = 1'b1; data_in = 8'h77;
    @(negedge clk); rdy = 1'b0; data_in = 8'h00;
    chk("R7 second back-to-back vector", vector, 8'h77);
    chk("R10 second pulse", vec_vld, 1'b1);
    repeat (3) @(negedge clk);
    chk_idle("R1 idle after request dropped");
  endtask

  task automatic t_reset_mid();
    irq = 1'b1; int_en = 1'b1;
    @(negedge clk); irq = 1'b0;
    repeat (2) @(negedge clk);
    chk_open("R3 waiting before reset", 1'b0, 30'd1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_idle("R11 abandoned cycle");
    chk("R11 vec_vld low", vec_vld, 1'b0);
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
    chk_idle("R11 stays idle");
    chk("R11 no pulse", vec_vld, 1'b0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    run_seq(0, 0, 8'hC3, 1'b0);
    run_seq(3, 5, 8'h00, 1'b0);
    run_seq(1, 2, 8'hFF, 1'b0);
    t_ignored();
    t_back_to_back();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule